// File: doc/BRIEF.md
# Snooping Line Coherence Controller with a Single Clean Supplier

This block holds the coherence state and tag of one cache line and keeps it consistent with the copies in peer caches on an atomic snooping bus. It uses an invalidation protocol with six states: Invalid, Shared, Shared-master, Exclusive, Owned and Modified. Dirty data can be shared. The Owned copy answers reads and keeps the writeback duty. Among clean sharers, only the Shared-master copy drives data. A read that misses while a clean copy exists is therefore served by one peer cache, not by memory and not by several caches competing for the data bus.

The local processor side issues read, write and evict requests. The block answers in the same cycle with the bus transaction it needs and any writeback of a dirty victim. The next state is loaded on the following clock edge. The bus side receives the transaction another cache has placed on the bus. For that transaction the block drives the shared copies-exist line and a data-supply action, which is either a dirty flush or an optional clean flush. The bus is modelled as atomic: the requester's transaction, all snoop responses and the wired-OR of copies-exist settle within one cycle.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset, `line_state` is Invalid and no bus request, supply action or writeback is raised. The state codes are Invalid=0, Shared=1, Shared-master=2, Exclusive=3, Owned=4 and Modified=5.
- R2: The processor op codes are read=0, write=1 and evict=2. The bus op codes are none=0, read=1, read-exclusive=2, upgrade=3, flush=4 and optional-flush=5. A read miss issues bus read (1) and loads the line as Exclusive when `copies_in` is low, or as Shared when it is high. A read hit issues nothing.
- R3: A snooped bus read that matches a valid line raises `copies_out`. An Exclusive line moves to Shared-master and raises `flushopt_out`. A Shared-master line stays Shared-master and raises `flushopt_out`. A Shared line raises neither supply output.
- R4: A Modified line that snoops a matching bus read moves to Owned and raises `flush_out` without a writeback. An Owned line stays Owned and raises `flush_out`.
- R5: A write hit in Exclusive or Modified issues no bus request and leaves the line Modified. A write hit in Shared, Shared-master or Owned issues upgrade (3) and moves to Modified.
- R6: A write miss issues read-exclusive (2), loads the new tag and moves to Modified.
- R7: A snooped read-exclusive or upgrade that matches a valid line moves it to Invalid. On read-exclusive, a Modified or Owned line raises `flush_out` first.
- R8: Evicting a Modified or Owned line raises `wb_req` with `wb_tag` equal to the line's tag. Evicting an Exclusive, Shared or Shared-master line raises no writeback. Either way the line becomes Invalid.
- R9: A miss that replaces a valid dirty line of another tag raises `wb_req` with the old tag in the same cycle as the bus request, and then holds the new tag.
- R10: When a snoop and a processor request arrive in the same cycle, the snoop is handled. `cpu_done` is low, no bus request is issued and the processor request has no effect.
- R11: Snooped flush (4), optional-flush (5) or none (0) ops, snoops with a non-matching tag, and snoops on an Invalid line change no state and raise no response.
- R12: With three controllers on one bus, at most one cache drives data for any bus read. At most one cache holds a given block in Modified, Exclusive, Owned or Shared-master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_valid | input | 1 | Processor request present |
| cpu_op | input | 2 | Processor op: 0 read, 1 write, 2 evict |
| cpu_tag | input | TAG_W | Tag of the processor request |
| cpu_done | output | 1 | Processor request performed this cycle |
| bus_req_op | output | 3 | Bus transaction issued by this cache (0 none) |
| bus_req_tag | output | TAG_W | Tag placed on the bus with the request |
| copies_in | input | 1 | Wired-OR of peers' copies-exist for this cache's request |
| snp_valid | input | 1 | Peer transaction on the bus this cycle |
| snp_op | input | 3 | Snooped bus op code |
| snp_tag | input | TAG_W | Snooped tag |
| copies_out | output | 1 | This cache holds a valid copy of the snooped read block |
| flush_out | output | 1 | Drive dirty data onto the bus |
| flushopt_out | output | 1 | Drive clean data onto the bus as the designated supplier |
| wb_req | output | 1 | Write the line's dirty data back to memory |
| wb_tag | output | TAG_W | Tag of the line being written back |
| line_state | output | 3 | Current coherence state code |
| line_tag | output | TAG_W | Tag currently held |

## Verification
The bench targets the second and third readers of a clean block. A design that let the supplier role move to the newest copy, or let plain sharers drive data, would show two supply actions on one read or two Shared-master holders, and the supplier invariant catches both. It forces a dirty line through Owned into a read-exclusive and through replacement. A design that dropped the flush or the writeback of the old tag, or that wrote back when moving from Modified to Owned, would show the wrong supply or writeback outputs. It also drives a snoop in the same cycle as a processor upgrade, and sends flush ops and mismatched tags. A controller that let the processor win the collision, or reacted to data transfers, would change state where it must hold.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [2:0] {
    ST_I  = 3'd0,
    ST_S  = 3'd1,
    ST_SM = 3'd2,
    ST_E  = 3'd3,
    ST_O  = 3'd4,
    ST_M  = 3'd5
  } line_st_e;

  typedef enum logic [2:0] {
    BOP_NONE     = 3'd0,
    BOP_RD       = 3'd1,
    BOP_RDX      = 3'd2,
    BOP_UPGR     = 3'd3,
    BOP_FLUSH    = 3'd4,
    BOP_FLUSHOPT = 3'd5
  } bus_op_e;

  typedef enum logic [1:0] {
    COP_READ  = 2'd0,
    COP_WRITE = 2'd1,
    COP_EVICT = 2'd2
  } cpu_op_e;

  typedef struct packed {
    logic copies;
    logic flush;
    logic flushopt;
  } snp_resp_t;

  function automatic logic is_dirty(line_st_e s);
    return (s == ST_M) || (s == ST_O);
  endfunction

endpackage

// File: rtl/coh_rst_sync.sv
module coh_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/coh_tag_cmp.sv
module coh_tag_cmp #(
  parameter int TAG_W = 12
) (
  input  logic             line_valid,
  input  logic [TAG_W-1:0] line_tag,
  input  logic [TAG_W-1:0] cpu_tag,
  input  logic [TAG_W-1:0] snp_tag,
  output logic             cpu_hit,
  output logic             snp_hit
);
  assign cpu_hit = line_valid && (line_tag == cpu_tag);
  assign snp_hit = line_valid && (line_tag == snp_tag);
endmodule

// File: rtl/coh_snoop_fsm.sv
module coh_snoop_fsm
  import coh_pkg::*;
(
  input  line_st_e  st,
  input  logic      snp_valid,
  input  logic [2:0] snp_op,
  input  logic      snp_hit,
  output logic      upd,
  output line_st_e  nxt,
  output snp_resp_t resp
);
  bus_op_e op;
  assign op = bus_op_e'(snp_op);

  always_comb begin
    upd  = 1'b0;
    nxt  = st;
    resp = '0;
    if (snp_valid && snp_hit) begin
      unique case (op)
        BOP_RD: begin
          resp.copies = 1'b1;
          unique case (st)
            ST_M: begin
              resp.flush = 1'b1;
              upd        = 1'b1;
              nxt        = ST_O;
            end
            ST_O:  resp.flush = 1'b1;
            ST_E: begin
              resp.flushopt = 1'b1;
              upd           = 1'b1;
              nxt           = ST_SM;
            end
            ST_SM: resp.flushopt = 1'b1;
            default: ;
          endcase
        end
        BOP_RDX: begin
          resp.flush = is_dirty(st);
          upd        = 1'b1;
          nxt        = ST_I;
        end
        BOP_UPGR: begin
          upd = 1'b1;
          nxt = ST_I;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/coh_cpu_fsm.sv
module coh_cpu_fsm
  import coh_pkg::*;
(
  input  line_st_e   st,
  input  logic       cpu_valid,
  input  logic [1:0] cpu_op,
  input  logic       cpu_hit,
  input  logic       copies_in,
  input  logic       blocked,
  output logic       upd,
  output line_st_e   nxt,
  output logic       tag_load,
  output bus_op_e    bop,
  output logic       wb,
  output logic       done
);
  cpu_op_e op;
  logic    dirty;
  assign op    = cpu_op_e'(cpu_op);
  assign dirty = is_dirty(st);

  always_comb begin
    upd      = 1'b0;
    nxt      = st;
    tag_load = 1'b0;
    bop      = BOP_NONE;
    wb       = 1'b0;
    done     = 1'b0;
    if (cpu_valid && !blocked) begin
      done = 1'b1;
      unique case (op)
        COP_READ: begin
          if (!cpu_hit) begin
            bop      = BOP_RD;
            wb       = dirty;
            tag_load = 1'b1;
            upd      = 1'b1;
            nxt      = copies_in ? ST_S : ST_E;
          end
        end
        COP_WRITE: begin
          if (!cpu_hit) begin
            bop      = BOP_RDX;
            wb       = dirty;
            tag_load = 1'b1;
            upd      = 1'b1;
            nxt      = ST_M;
          end else begin
            unique case (st)
              ST_E: begin
                upd = 1'b1;
                nxt = ST_M;
              end
              ST_S, ST_SM, ST_O: begin
                bop = BOP_UPGR;
                upd = 1'b1;
                nxt = ST_M;
              end
              default: ;
            endcase
          end
        end
        COP_EVICT: begin
          if (st != ST_I) begin
            wb  = dirty;
            upd = 1'b1;
            nxt = ST_I;
          end
        end
        default: done = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/coh_line_reg.sv
module coh_line_reg
  import coh_pkg::*;
#(
  parameter int TAG_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             st_en,
  input  line_st_e         st_d,
  input  logic             tag_en,
  input  logic [TAG_W-1:0] tag_d,
  output line_st_e         st_q,
  output logic [TAG_W-1:0] tag_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= ST_I;
    else if (st_en) st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tag_q <= '0;
    else if (tag_en) tag_q <= tag_d;
  end
endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
  import coh_pkg::*;
#(
  parameter int TAG_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_valid,
  input  logic [1:0]       cpu_op,
  input  logic [TAG_W-1:0] cpu_tag,
  output logic             cpu_done,
  output logic [2:0]       bus_req_op,
  output logic [TAG_W-1:0] bus_req_tag,
  input  logic             copies_in,
  input  logic             snp_valid,
  input  logic [2:0]       snp_op,
  input  logic [TAG_W-1:0] snp_tag,
  output logic             copies_out,
  output logic             flush_out,
  output logic             flushopt_out,
  output logic             wb_req,
  output logic [TAG_W-1:0] wb_tag,
  output logic [2:0]       line_state,
  output logic [TAG_W-1:0] line_tag
);
  logic             rst_n_sync;
  line_st_e         st_q, st_d, snp_nxt, cpu_nxt;
  logic [TAG_W-1:0] tag_q;
  logic             st_en, tag_en;
  logic             cpu_hit, snp_hit;
  logic             snp_upd, cpu_upd, cpu_tag_load, cpu_wb;
  snp_resp_t        resp;
  bus_op_e          cpu_bop;

  coh_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_n_sync)
  );

  coh_tag_cmp #(.TAG_W(TAG_W)) i_tag_cmp (
    .line_valid (st_q != ST_I),
    .line_tag   (tag_q),
    .cpu_tag    (cpu_tag),
    .snp_tag    (snp_tag),
    .cpu_hit    (cpu_hit),
    .snp_hit    (snp_hit)
  );

  coh_snoop_fsm i_snoop_fsm (
    .st        (st_q),
    .snp_valid (snp_valid),
    .snp_op    (snp_op),
    .snp_hit   (snp_hit),
    .upd       (snp_upd),
    .nxt       (snp_nxt),
    .resp      (resp)
  );

  coh_cpu_fsm i_cpu_fsm (
    .st        (st_q),
    .cpu_valid (cpu_valid),
    .cpu_op    (cpu_op),
    .cpu_hit   (cpu_hit),
    .copies_in (copies_in),
    .blocked   (snp_valid),
    .upd       (cpu_upd),
    .nxt       (cpu_nxt),
    .tag_load  (cpu_tag_load),
    .bop       (cpu_bop),
    .wb        (cpu_wb),
    .done      (cpu_done)
  );

  always_comb begin
    if (snp_valid) begin
      st_en  = snp_upd;
      st_d   = snp_nxt;
      tag_en = 1'b0;
    end else begin
      st_en  = cpu_upd;
      st_d   = cpu_nxt;
      tag_en = cpu_tag_load;
    end
  end

  coh_line_reg #(.TAG_W(TAG_W)) i_line_reg (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .st_en  (st_en),
    .st_d   (st_d),
    .tag_en (tag_en),
    .tag_d  (cpu_tag),
    .st_q   (st_q),
    .tag_q  (tag_q)
  );

  assign bus_req_op   = cpu_bop;
  assign bus_req_tag  = cpu_tag;
  assign copies_out   = resp.copies;
  assign flush_out    = resp.flush;
  assign flushopt_out = resp.flushopt;
  assign wb_req       = cpu_wb;
  assign wb_tag       = tag_q;
  assign line_state   = st_q;
  assign line_tag     = tag_q;
endmodule

// File: rtl/coh_line_chk.sv
module coh_line_chk
  import coh_pkg::*;
#(
  parameter int TAG_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_valid,
  input logic [TAG_W-1:0] cpu_tag,
  input logic [2:0]       bus_req_op,
  input logic             copies_in,
  input logic             snp_valid,
  input logic [2:0]       snp_op,
  input logic [TAG_W-1:0] snp_tag,
  input logic             copies_out,
  input logic             flush_out,
  input logic             flushopt_out,
  input logic             wb_req,
  input logic [2:0]       line_state,
  input logic [TAG_W-1:0] line_tag
);
  logic snp_match;
  assign snp_match = snp_valid && (line_state != ST_I) && (snp_tag == line_tag);

  assert_one_supply_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(flush_out && flushopt_out));

  assert_fopt_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    flushopt_out |-> (line_state == ST_E || line_state == ST_SM));

  assert_copies_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    copies_out |-> (line_state != ST_I));

  assert_e_to_sm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_match && snp_op == BOP_RD && line_state == ST_E) |=> (line_state == ST_SM));

  assert_flush_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flush_out |-> (line_state == ST_M || line_state == ST_O));

  assert_m_to_o_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_match && snp_op == BOP_RD && line_state == ST_M) |=> (line_state == ST_O));

  assert_rd_install_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_op == BOP_RD) |=> (line_state == ($past(copies_in) ? ST_S : ST_E)));

  assert_upgrade_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_op == BOP_UPGR) |=> (line_state == ST_M));

  assert_rdx_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_op == BOP_RDX) |=> (line_state == ST_M && line_tag == $past(cpu_tag)));

  assert_invalidate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_match && (snp_op == BOP_RDX || snp_op == BOP_UPGR)) |=> (line_state == ST_I));

  assert_wb_dirty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> (line_state == ST_M || line_state == ST_O));

  assert_snoop_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && cpu_valid) |-> (bus_req_op == BOP_NONE && !wb_req));

  assert_ignore_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && (snp_op == BOP_FLUSH || snp_op == BOP_FLUSHOPT))
      |=> $stable(line_state));
endmodule

bind coh_line_ctrl coh_line_chk #(.TAG_W(TAG_W)) i_coh_line_chk (
  .clk          (clk),
  .rst_n        (rst_n_sync),
  .cpu_valid    (cpu_valid),
  .cpu_tag      (cpu_tag),
  .bus_req_op   (bus_req_op),
  .copies_in    (copies_in),
  .snp_valid    (snp_valid),
  .snp_op       (snp_op),
  .snp_tag      (snp_tag),
  .copies_out   (copies_out),
  .flush_out    (flush_out),
  .flushopt_out (flushopt_out),
  .wb_req       (wb_req),
  .line_state   (line_state),
  .line_tag     (line_tag)
);

// File: tb/test_coh_line_ctrl.sv
module test_coh_line_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N          = 3;
  localparam int TAG_W      = 12;
  localparam logic [TAG_W-1:0] TAG_A = 12'h1a5;
  localparam logic [TAG_W-1:0] TAG_B = 12'h2c3;

  localparam int SI = 0, SS = 1, SSM = 2, SE = 3, SO = 4, SMOD = 5;
  localparam int BNONE = 0, BRD = 1, BRDX = 2, BUPGR = 3, BFL = 4, BFOPT = 5;
  localparam logic [1:0] OPR = 2'd0, OPW = 2'd1, OPEV = 2'd2;

  logic clk, rst_n;
  logic             cpu_valid    [N];
  logic [1:0]       cpu_op       [N];
  logic [TAG_W-1:0] cpu_tag      [N];
  logic             cpu_done     [N];
  logic [2:0]       bus_req_op   [N];
  logic [TAG_W-1:0] bus_req_tag  [N];
  logic             copies_in    [N];
  logic             snp_valid    [N];
  logic [2:0]       snp_op       [N];
  logic [TAG_W-1:0] snp_tag      [N];
  logic             copies_out   [N];
  logic             flush_out    [N];
  logic             flushopt_out [N];
  logic             wb_req       [N];
  logic [TAG_W-1:0] wb_tag       [N];
  logic [2:0]       line_state   [N];
  logic [TAG_W-1:0] line_tag     [N];

  logic             ext_en;
  logic [2:0]       ext_op;
  logic [TAG_W-1:0] ext_tag;
  int               bus_src;

  int n_checks, n_errors;
  bit finished;

  int cap_bus [N];
  int cap_fl  [N];
  int cap_fo  [N];
  int cap_cin [N];
  int cap_cout[N];
  int cap_wb  [N];
  int cap_wbt [N];
  int cap_done[N];

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  for (genvar g = 0; g < N; g++) begin : g_node
    coh_line_ctrl #(.TAG_W(TAG_W)) i_coh_line_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .cpu_valid    (cpu_valid[g]),
      .cpu_op       (cpu_op[g]),
      .cpu_tag      (cpu_tag[g]),
      .cpu_done     (cpu_done[g]),
      .bus_req_op   (bus_req_op[g]),
      .bus_req_tag  (bus_req_tag[g]),
      .copies_in    (copies_in[g]),
      .snp_valid    (snp_valid[g]),
      .snp_op       (snp_op[g]),
      .snp_tag      (snp_tag[g]),
      .copies_out   (copies_out[g]),
      .flush_out    (flush_out[g]),
      .flushopt_out (flushopt_out[g]),
      .wb_req       (wb_req[g]),
      .wb_tag       (wb_tag[g]),
      .line_state   (line_state[g]),
      .line_tag     (line_tag[g])
    );
  end

  // Bus fabric: the requesting cache is the one the bench drives.
  always_comb begin
    bus_src = -1;
    for (int i = 0; i < N; i++) if (cpu_valid[i]) bus_src = i;
  end

  always_comb begin
    for (int j = 0; j < N; j++) begin
      if (ext_en) begin
        snp_valid[j] = 1'b1;
        snp_tag[j]   = ext_tag;
      end else begin
        snp_valid[j] = (bus_src >= 0) && (bus_src != j);
        snp_tag[j]   = (bus_src >= 0) ? cpu_tag[bus_src] : '0;
      end
    end
  end

  always_comb begin
    for (int j = 0; j < N; j++)
      snp_op[j] = ext_en ? ext_op : ((bus_src >= 0) ? bus_req_op[bus_src] : 3'd0);
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      copies_in[i] = 1'b0;
      for (int j = 0; j < N; j++)
        if (j != i) copies_in[i] = copies_in[i] | copies_out[j];
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic capture();
    int sup;
    sup = 0;
    for (int i = 0; i < N; i++) begin
      cap_bus[i]  = int'(bus_req_op[i]);
      cap_fl[i]   = int'(flush_out[i]);
      cap_fo[i]   = int'(flushopt_out[i]);
      cap_cin[i]  = int'(copies_in[i]);
      cap_cout[i] = int'(copies_out[i]);
      cap_wb[i]   = int'(wb_req[i]);
      cap_wbt[i]  = int'(wb_tag[i]);
      cap_done[i] = int'(cpu_done[i]);
      sup += cap_fl[i] + cap_fo[i];
    end
    chk("R12", "supplier count <= 1", (sup <= 1) ? 1 : 0, 1);
  endtask

  task automatic check_invariant();
    int worst;
    worst = 0;
    for (int i = 0; i < N; i++) begin
      int cnt;
      cnt = 0;
      for (int j = 0; j < N; j++)
        if (line_state[j] inside {3'd2, 3'd3, 3'd4, 3'd5} &&
            line_state[i] inside {3'd2, 3'd3, 3'd4, 3'd5} &&
            line_tag[j] == line_tag[i]) cnt++;
      if (cnt > worst) worst = cnt;
    end
    chk("R12", "max single-holder states per block", (worst <= 1) ? worst : worst, (worst <= 1) ? worst : 1);
  endtask

  task automatic do_op(input int idx, input logic [1:0] op, input logic [TAG_W-1:0] tag);
    @(negedge clk);
    cpu_valid[idx] = 1'b1;
    cpu_op[idx]    = op;
    cpu_tag[idx]   = tag;
    #1 capture();
    @(negedge clk);
    cpu_valid[idx] = 1'b0;
    #1 check_invariant();
  endtask

  task automatic snoop(input logic [2:0] op, input logic [TAG_W-1:0] tag);
    @(negedge clk);
    ext_en  = 1'b1;
    ext_op  = op;
    ext_tag = tag;
    #1 capture();
    @(negedge clk);
    ext_en = 1'b0;
    #1 check_invariant();
  endtask

  task automatic t_reset();
    for (int i = 0; i < N; i++) begin
      chk("R1", "state after reset", int'(line_state[i]), SI);
      chk("R1", "bus request after reset", int'(bus_req_op[i]), BNONE);
      chk("R1", "supply after reset", int'(flush_out[i] | flushopt_out[i] | wb_req[i]), 0);
    end
  endtask

  task automatic t_read_exclusive();
    do_op(0, OPR, TAG_A);
    chk("R2", "read miss bus op", cap_bus[0], BRD);
    chk("R2", "copies_in on lone read", cap_cin[0], 0);
    chk("R2", "lone reader state", int'(line_state[0]), SE);
    do_op(0, OPR, TAG_A);
    chk("R2", "read hit bus op", cap_bus[0], BNONE);
  endtask

  task automatic t_master_supply();
    do_op(1, OPR, TAG_A);
    chk("R3", "E supplies FlushOpt", cap_fo[0], 1);
    chk("R3", "E raises copies", cap_cout[0], 1);
    chk("R2", "second reader sees copies", cap_cin[1], 1);
    chk("R3", "E becomes master", int'(line_state[0]), SSM);
    chk("R2", "second reader state", int'(line_state[1]), SS);
    do_op(2, OPR, TAG_A);
    chk("R3", "master supplies again", cap_fo[0], 1);
    chk("R3", "plain sharer silent", cap_fo[1] + cap_fl[1], 0);
    chk("R3", "sharer raises copies", cap_cout[1], 1);
    chk("R3", "master role kept", int'(line_state[0]), SSM);
    chk("R3", "newest reader not master", int'(line_state[2]), SS);
  endtask

  task automatic t_upgrade_and_owned();
    do_op(1, OPW, TAG_A);
    chk("R5", "write hit in S bus op", cap_bus[1], BUPGR);
    chk("R5", "upgrader state", int'(line_state[1]), SMOD);
    chk("R7", "master invalidated by upgrade", int'(line_state[0]), SI);
    chk("R7", "sharer invalidated by upgrade", int'(line_state[2]), SI);
    do_op(2, OPR, TAG_A);
    chk("R4", "M flushes on read", cap_fl[1], 1);
    chk("R4", "no writeback on M to O", cap_wb[1], 0);
    chk("R4", "M becomes O", int'(line_state[1]), SO);
    chk("R2", "reader of dirty block state", int'(line_state[2]), SS);
    do_op(0, OPR, TAG_A);
    chk("R4", "O flushes again", cap_fl[1], 1);
    chk("R4", "O stays O", int'(line_state[1]), SO);
  endtask

  task automatic t_rdx();
    do_op(0, OPEV, TAG_A);
    chk("R8", "S evict silent", cap_wb[0], 0);
    chk("R8", "S evict to I", int'(line_state[0]), SI);
    do_op(0, OPW, TAG_A);
    chk("R6", "write miss bus op", cap_bus[0], BRDX);
    chk("R7", "O flushes on RdX", cap_fl[1], 1);
    chk("R7", "S no flush on RdX", cap_fl[2], 0);
    chk("R6", "writer state", int'(line_state[0]), SMOD);
    chk("R7", "O invalidated", int'(line_state[1]), SI);
    chk("R7", "S invalidated", int'(line_state[2]), SI);
  endtask

  task automatic t_replace_and_silent_write();
    do_op(0, OPR, TAG_B);
    chk("R9", "replacement bus op", cap_bus[0], BRD);
    chk("R9", "replacement writeback", cap_wb[0], 1);
    chk("R9", "writeback carries old tag", cap_wbt[0], int'(TAG_A));
    chk("R9", "new tag held", int'(line_tag[0]), int'(TAG_B));
    chk("R2", "replaced line exclusive", int'(line_state[0]), SE);
    do_op(0, OPW, TAG_B);
    chk("R5", "E write silent", cap_bus[0], BNONE);
    chk("R5", "E write to M", int'(line_state[0]), SMOD);
    do_op(0, OPW, TAG_B);
    chk("R5", "M write silent", cap_bus[0], BNONE);
    chk("R5", "M stays M", int'(line_state[0]), SMOD);
  endtask

  task automatic t_evict();
    do_op(0, OPEV, TAG_B);
    chk("R8", "M evict writeback", cap_wb[0], 1);
    chk("R8", "M evict tag", cap_wbt[0], int'(TAG_B));
    chk("R8", "M evict to I", int'(line_state[0]), SI);
    do_op(1, OPR, TAG_B);
    do_op(1, OPEV, TAG_B);
    chk("R8", "E evict silent", cap_wb[1], 0);
    do_op(1, OPW, TAG_B);
    do_op(2, OPR, TAG_B);
    chk("R4", "setup owned line", int'(line_state[1]), SO);
    do_op(1, OPEV, TAG_B);
    chk("R8", "O evict writeback", cap_wb[1], 1);
    chk("R8", "O evict tag", cap_wbt[1], int'(TAG_B));
    chk("R8", "O evict to I", int'(line_state[1]), SI);
  endtask

  task automatic t_priority();
    @(negedge clk);
    ext_en  = 1'b1;
    ext_op  = 3'(BFL);
    ext_tag = TAG_B;
    cpu_valid[2] = 1'b1;
    cpu_op[2]    = OPW;
    cpu_tag[2]   = TAG_B;
    #1 capture();
    @(negedge clk);
    ext_en       = 1'b0;
    cpu_valid[2] = 1'b0;
    #1;
    chk("R10", "cpu_done under snoop", cap_done[2], 0);
    chk("R10", "no bus request under snoop", cap_bus[2], BNONE);
    chk("R10", "state unchanged by blocked write", int'(line_state[2]), SS);
  endtask

  task automatic t_ignore();
    snoop(3'(BRDX), TAG_A);
    chk("R11", "mismatched RdX leaves S", int'(line_state[2]), SS);
    snoop(3'(BFOPT), TAG_B);
    chk("R11", "FlushOpt snoop no copies", cap_cout[2], 0);
    chk("R11", "FlushOpt snoop leaves S", int'(line_state[2]), SS);
    snoop(3'(BRD), TAG_B);
    chk("R3", "sharer copies on read", cap_cout[2], 1);
    chk("R3", "sharer never supplies", cap_fl[2] + cap_fo[2], 0);
    snoop(3'(BRD), TAG_A);
    chk("R11", "mismatched read no copies", cap_cout[2], 0);
    snoop(3'(BUPGR), TAG_B);
    chk("R7", "upgrade snoop invalidates S", int'(line_state[2]), SI);
    snoop(3'(BRD), TAG_B);
    chk("R11", "invalid line no copies", cap_cout[2], 0);
  endtask

  initial begin
    n_checks = 0;
    n_errors = 0;
    finished = 1'b0;
    ext_en   = 1'b0;
    ext_op   = '0;
    ext_tag  = '0;
    for (int i = 0; i < N; i++) begin
      cpu_valid[i] = 1'b0;
      cpu_op[i]    = '0;
      cpu_tag[i]   = '0;
    end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    t_reset();
    t_read_exclusive();
    t_master_supply();
    t_upgrade_and_owned();
    t_rdx();
    t_replace_and_silent_write();
    t_evict();
    t_priority();
    t_ignore();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_errors++;
      $display("FAIL watchdog (all requirements): actual hung run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule